// File: doc/BRIEF.md
# Saturating Arithmetic Unit with Sticky Flag

This block is a registered 32-bit integer unit that runs one of ten clamp-style operations per accepted request. A 4-bit opcode picks the operation: signed or unsigned add and subtract that pin to the range limits instead of wrapping, a signed doubling, signed and unsigned clamping of operand A to a bit position, the same two clamps applied on their own to each 16-bit half, and an add that returns the wrapped sum but still reports signed overflow.

Every operation that clamps, and the flag-only add when it overflows, raises a sticky saturation flag. Only reset or the clear input lowers it. A datapath can therefore run a batch of operations and test once, at the end, whether any of them hit a limit. Results and the flag change on the clock edge that samples a valid request.

Top module: `sat_alu`

## Requirements
- R1: Opcode 0 (signed add): when A and B share a sign and A+B does not have A's sign, the result is 0x7FFFFFFF for non-negative A and 0x80000000 for negative A, and the flag is set. Otherwise the result is the plain sum.
- R2: Opcode 1 (signed subtract): when A and B differ in sign and A-B does not have A's sign, the result is clamped by A's sign as in R1 and the flag is set. Otherwise the result is A-B.
- R3: Opcode 2 (signed doubling of A): when A is at least 0x40000000 the result is 0x7FFFFFFF. When A is at most 0xC0000000 (signed, so 0xC0000000 itself counts) the result is 0x80000000. Both cases set the flag. Otherwise the result is A shifted left by one.
- R4: Opcode 3 (unsigned add) returns 0xFFFFFFFF and sets the flag when A+B carries out of bit 31. Opcode 4 (unsigned subtract) returns 0 and sets the flag when B > A unsigned. Otherwise each returns the plain result.
- R5: Opcode 5 (signed clamp of A to position n = pos_i, 0..31): when A arithmetically shifted right by n is above 0, the result is 2^n-1. When it is below -1, the result is the bitwise complement of 2^n-1. Both cases set the flag. Otherwise A is returned unchanged.
- R6: Opcode 6 (unsigned clamp of A to position n): a negative A gives 0. An A above 2^n-1 gives 2^n-1. Both cases set the flag. Otherwise A is returned unchanged.
- R7: Opcodes 7 and 8 apply the R5 and R6 rules separately to the sign-extended halves A[15:0] and A[31:16]. The low 16 bits of each outcome go back into the same half. Either half clamping sets the flag.
- R8: Opcode 9 (flag-only add) returns the wrapped 32-bit A+B and sets the flag under the R1 overflow condition.
- R9: The flag is sticky: once set, it stays high through later non-clamping operations and idle cycles.
- R10: A clear pulse with no clamp event in the same accepted request drops the flag on the next edge. When a clear and a clamp event coincide, the flag stays set.
- R11: After reset the result and the flag are 0. When valid_i is low, the result and the flag keep their values, whatever the opcode and operands are.
- R12: Opcodes 10 to 15 give result 0 and never set the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe; the operation is taken on this edge |
| clr_i | input | 1 | Clears the sticky flag |
| op_i | input | 4 | Operation select |
| pos_i | input | 5 | Clamp bit position n |
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B |
| result_o | output | 32 | Registered result |
| flag_o | output | 1 | Sticky saturation flag |

## Verification
The checker assumes that op_i, a_i, b_i and pos_i are steady and known at every edge where valid_i is high. It also assumes that clr_i is never left unknown, because the hold and clear properties read it on every cycle. The bench changes all inputs only at the falling edge and holds them for one full cycle. It pulses the clear with valid_i low before each table vector, so each flag check sees only that vector's own clamp event. Coincident clear and clamp requests are covered only by the directed priority test.

// File: rtl/sat_alu_pkg.sv
package sat_alu_pkg;
  typedef enum logic [3:0] {
    OP_SADD   = 4'd0,
    OP_SSUB   = 4'd1,
    OP_SDBL   = 4'd2,
    OP_UADD   = 4'd3,
    OP_USUB   = 4'd4,
    OP_SPOS   = 4'd5,
    OP_UPOS   = 4'd6,
    OP_SPOS16 = 4'd7,
    OP_UPOS16 = 4'd8,
    OP_QADD   = 4'd9
  } sat_op_e;
endpackage

// File: rtl/sat_word_ops.sv
module sat_word_ops #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [3:0]    op_i,
  output logic [DW-1:0] res_o,
  output logic          evt_o
);
  import sat_alu_pkg::*;

  localparam int MSB = DW - 1;
  localparam logic [DW-1:0] SMAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] SMIN = {1'b1, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] DNEG = {2'b11, {(DW-2){1'b0}}};

  logic [DW:0]   sum;
  logic [DW-1:0] diff, sclamp;
  logic          sadd_ovf, ssub_ovf, dbl_pos, dbl_neg, borrow;

  assign sum      = {1'b0, a_i} + {1'b0, b_i};
  assign diff     = a_i - b_i;
  assign sadd_ovf = (a_i[MSB] == b_i[MSB]) && (sum[MSB] != a_i[MSB]);
  assign ssub_ovf = (a_i[MSB] != b_i[MSB]) && (diff[MSB] != a_i[MSB]);
  assign sclamp   = a_i[MSB] ? SMIN : SMAX;
  assign dbl_pos  = a_i[MSB -: 2] == 2'b01;
  // 0xC0000000 itself lands on the limit but still counts as a clamp
  assign dbl_neg  = (a_i[MSB -: 2] == 2'b10) || (a_i == DNEG);
  assign borrow   = b_i > a_i;

  always_comb begin
    res_o = '0;
    evt_o = 1'b0;
    case (op_i)
      OP_SADD: begin res_o = sadd_ovf ? sclamp : sum[DW-1:0]; evt_o = sadd_ovf; end
      OP_SSUB: begin res_o = ssub_ovf ? sclamp : diff;        evt_o = ssub_ovf; end
      OP_SDBL: begin
        res_o = dbl_pos ? SMAX : dbl_neg ? SMIN : {a_i[DW-2:0], 1'b0};
        evt_o = dbl_pos | dbl_neg;
      end
      OP_UADD: begin res_o = sum[DW] ? '1 : sum[DW-1:0]; evt_o = sum[DW]; end
      OP_USUB: begin res_o = borrow ? '0 : diff;         evt_o = borrow;  end
      OP_QADD: begin res_o = sum[DW-1:0];                evt_o = sadd_ovf; end
      default: ;
    endcase
  end
endmodule

// File: rtl/sat_pos_clamp.sv
module sat_pos_clamp #(
  parameter int W  = 32,
  parameter int OW = 32,
  parameter int PW = $clog2(W)
) (
  input  logic [W-1:0]  val_i,
  input  logic [PW-1:0] pos_i,
  output logic [OW-1:0] s_res_o,
  output logic          s_evt_o,
  output logic [OW-1:0] u_res_o,
  output logic          u_evt_o
);
  logic [W-1:0] mask, top;
  logic         neg, s_hi, s_lo, u_hi;

  assign mask = ({{(W-1){1'b0}}, 1'b1} << pos_i) - 1'b1;
  assign top  = W'($signed(val_i) >>> pos_i);
  assign neg  = val_i[W-1];
  assign s_hi = !neg && (top != '0);
  assign s_lo = neg && (top != '1);
  assign u_hi = !neg && (val_i > mask);

  assign s_res_o = OW'(s_hi ? mask : s_lo ? ~mask : val_i);
  assign s_evt_o = s_hi | s_lo;
  assign u_res_o = OW'(neg ? '0 : u_hi ? mask : val_i);
  assign u_evt_o = neg | u_hi;
endmodule

// File: rtl/sat_sticky.sv
module sat_sticky (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;   // set wins over clear
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/sat_alu.sv
module sat_alu #(
  parameter int DW = 32,
  parameter int PW = $clog2(DW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          clr_i,
  input  logic [3:0]    op_i,
  input  logic [PW-1:0] pos_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] result_o,
  output logic          flag_o
);
  import sat_alu_pkg::*;

  localparam int HW    = DW / 2;
  localparam int LANES = 2;

  logic [DW-1:0] w_res, sw_res, uw_res, sh_res, uh_res, nxt_res;
  logic          w_evt, sw_evt, uw_evt, nxt_evt;
  logic [LANES-1:0] sh_evt, uh_evt;

  sat_word_ops #(.DW(DW)) u_word (
    .a_i(a_i), .b_i(b_i), .op_i(op_i), .res_o(w_res), .evt_o(w_evt)
  );

  sat_pos_clamp #(.W(DW), .OW(DW)) u_pos_w (
    .val_i(a_i), .pos_i(pos_i),
    .s_res_o(sw_res), .s_evt_o(sw_evt), .u_res_o(uw_res), .u_evt_o(uw_evt)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [HW-1:0] half;
    logic [DW-1:0] ext;
    assign half = a_i[k*HW +: HW];
    assign ext  = {{(DW-HW){half[HW-1]}}, half};
    sat_pos_clamp #(.W(DW), .OW(HW)) u_pos_h (
      .val_i(ext), .pos_i(pos_i),
      .s_res_o(sh_res[k*HW +: HW]), .s_evt_o(sh_evt[k]),
      .u_res_o(uh_res[k*HW +: HW]), .u_evt_o(uh_evt[k])
    );
  end

  always_comb begin
    nxt_res = w_res;
    nxt_evt = w_evt;
    case (op_i)
      OP_SPOS:   begin nxt_res = sw_res; nxt_evt = sw_evt;  end
      OP_UPOS:   begin nxt_res = uw_res; nxt_evt = uw_evt;  end
      OP_SPOS16: begin nxt_res = sh_res; nxt_evt = |sh_evt; end
      OP_UPOS16: begin nxt_res = uh_res; nxt_evt = |uh_evt; end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      result_o <= '0;
    else if (valid_i) result_o <= nxt_res;
  end

  sat_sticky u_flag (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .set_i(valid_i & nxt_evt), .clr_i(clr_i), .flag_o(flag_o)
  );
endmodule

// File: rtl/sat_alu_chk.sv
module sat_alu_chk #(
  parameter int DW = 32,
  parameter int PW = $clog2(DW)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic          clr_i,
  input logic [3:0]    op_i,
  input logic [PW-1:0] pos_i,
  input logic [DW-1:0] a_i,
  input logic [DW-1:0] b_i,
  input logic [DW-1:0] result_o,
  input logic          flag_o
);
  logic [DW:0]   usum;
  logic [DW-1:0] smax, smin;
  logic          pos_seen;
  assign usum = {1'b0, a_i} + {1'b0, b_i};
  assign smax = {1'b0, {(DW-1){1'b1}}};
  assign smin = {1'b1, {(DW-1){1'b0}}};
  assign pos_seen = |pos_i | 1'b1;

  AST_SADD_POS_CLAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == 4'd0 && !a_i[DW-1] && !b_i[DW-1] && usum[DW-1]
    |=> result_o == smax && flag_o); // R1

  AST_SSUB_NEG_CLAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == 4'd1 && a_i == smin && b_i == {{(DW-1){1'b0}}, 1'b1}
    |=> result_o == smin && flag_o); // R2

  AST_USUB_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == 4'd4 && b_i > a_i |=> result_o == '0 && flag_o); // R4

  AST_UADD_CEIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == 4'd3 && usum[DW] |=> result_o == '1 && flag_o); // R4

  AST_UPOS_NEG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == 4'd6 && a_i[DW-1] && pos_seen
    |=> result_o == '0 && flag_o); // R6

  AST_QADD_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == 4'd9 |=> result_o == $past(usum[DW-1:0])); // R8

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o && !clr_i |=> flag_o); // R9

  AST_FLAG_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !valid_i |=> !flag_o); // R10

  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o)); // R11

  AST_BAD_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i >= 4'd10 |=> result_o == '0); // R12
endmodule

bind sat_alu sat_alu_chk #(.DW(DW), .PW(PW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .clr_i(clr_i),
  .op_i(op_i), .pos_i(pos_i), .a_i(a_i), .b_i(b_i),
  .result_o(result_o), .flag_o(flag_o)
);

// File: tb/sim_sat_alu.sv
`timescale 1ns/1ps
module sim_sat_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic        clr = 1'b0;
  logic [3:0]  op = '0;
  logic [4:0]  pos = '0;
  logic [31:0] a = '0, b = '0;
  logic [31:0] result;
  logic        flag;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sat_alu u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .clr_i(clr),
    .op_i(op), .pos_i(pos), .a_i(a), .b_i(b),
    .result_o(result), .flag_o(flag)
  );

  // {op, pos, a, b, expected result, expected flag}
  localparam int NV = 32;
  localparam logic [105:0] VEC [NV] = '{
    {4'd0, 5'd0, 32'h7FFFFFFF, 32'h00000001, 32'h7FFFFFFF, 1'b1}, // R1
    {4'd0, 5'd0, 32'h80000000, 32'hFFFFFFFF, 32'h80000000, 1'b1}, // R1
    {4'd0, 5'd0, 32'h00000005, 32'hFFFFFFFD, 32'h00000002, 1'b0}, // R1
    {4'd0, 5'd0, 32'h7FFFFFFE, 32'h00000001, 32'h7FFFFFFF, 1'b0}, // R1
    {4'd1, 5'd0, 32'h80000000, 32'h00000001, 32'h80000000, 1'b1}, // R2
    {4'd1, 5'd0, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'h7FFFFFFF, 1'b1}, // R2
    {4'd1, 5'd0, 32'h00000010, 32'h00000003, 32'h0000000D, 1'b0}, // R2
    {4'd2, 5'd0, 32'h40000000, 32'h0,        32'h7FFFFFFF, 1'b1}, // R3
    {4'd2, 5'd0, 32'h3FFFFFFF, 32'h0,        32'h7FFFFFFE, 1'b0}, // R3
    {4'd2, 5'd0, 32'hC0000000, 32'h0,        32'h80000000, 1'b1}, // R3
    {4'd2, 5'd0, 32'hC0000001, 32'h0,        32'h80000002, 1'b0}, // R3
    {4'd3, 5'd0, 32'hFFFFFFFF, 32'h00000001, 32'hFFFFFFFF, 1'b1}, // R4
    {4'd3, 5'd0, 32'hFFFFFFFE, 32'h00000001, 32'hFFFFFFFF, 1'b0}, // R4
    {4'd4, 5'd0, 32'h00000005, 32'h00000006, 32'h00000000, 1'b1}, // R4
    {4'd4, 5'd0, 32'h00000006, 32'h00000006, 32'h00000000, 1'b0}, // R4
    {4'd5, 5'd7, 32'h0000007F, 32'h0,        32'h0000007F, 1'b0}, // R5
    {4'd5, 5'd7, 32'h00000080, 32'h0,        32'h0000007F, 1'b1}, // R5
    {4'd5, 5'd7, 32'hFFFFFF80, 32'h0,        32'hFFFFFF80, 1'b0}, // R5
    {4'd5, 5'd7, 32'hFFFFFF7F, 32'h0,        32'hFFFFFF80, 1'b1}, // R5
    {4'd5, 5'd31, 32'h80000000, 32'h0,       32'h80000000, 1'b0}, // R5
    {4'd6, 5'd8, 32'h000000FF, 32'h0,        32'h000000FF, 1'b0}, // R6
    {4'd6, 5'd8, 32'h00000100, 32'h0,        32'h000000FF, 1'b1}, // R6
    {4'd6, 5'd8, 32'hFFFFFFFF, 32'h0,        32'h00000000, 1'b1}, // R6
    {4'd6, 5'd31, 32'h7FFFFFFF, 32'h0,       32'h7FFFFFFF, 1'b0}, // R6
    {4'd7, 5'd7, 32'h0100FF00, 32'h0,        32'h007FFF80, 1'b1}, // R7
    {4'd7, 5'd7, 32'h007FFF80, 32'h0,        32'h007FFF80, 1'b0}, // R7
    {4'd8, 5'd4, 32'h80000005, 32'h0,        32'h00000005, 1'b1}, // R7
    {4'd8, 5'd4, 32'h000F000F, 32'h0,        32'h000F000F, 1'b0}, // R7
    {4'd9, 5'd0, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 1'b1}, // R8
    {4'd9, 5'd0, 32'h00000001, 32'h00000002, 32'h00000003, 1'b0}, // R8
    {4'd10, 5'd0, 32'h00001234, 32'h1,       32'h00000000, 1'b0}, // R12
    {4'd15, 5'd3, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000, 1'b0} // R12
  };

  function automatic string req_of(input logic [3:0] o);
    case (o)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2: return "R3";
      4'd3, 4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7, 4'd8: return "R7";
      4'd9: return "R8";
      default: return "R12";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [3:0] o, input logic [4:0] p,
                        input logic [31:0] x, input logic [31:0] y, input logic c);
    @(negedge clk);
    op = o; pos = p; a = x; b = y; valid = 1'b1; clr = c;
    @(negedge clk);
    valid = 1'b0; clr = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset result", result, 32'h0);
    chk("R11 reset flag", {31'b0, flag}, 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      pulse_clr();
      run_op(VEC[i][105:102], VEC[i][101:97], VEC[i][96:65], VEC[i][64:33], 1'b0);
      chk($sformatf("%s vec%0d result", req_of(VEC[i][105:102]), i), result, VEC[i][32:1]);
      chk($sformatf("%s vec%0d flag", req_of(VEC[i][105:102]), i), {31'b0, flag}, {31'b0, VEC[i][0]});
    end

    // R9: flag survives later clean ops and idle cycles
    pulse_clr();
    run_op(4'd3, 5'd0, 32'hFFFFFFFF, 32'h2, 1'b0);
    run_op(4'd0, 5'd0, 32'h1, 32'h1, 1'b0);
    chk("R9 clean op result", result, 32'h2);
    repeat (4) @(negedge clk);
    chk("R9 sticky flag", {31'b0, flag}, 32'h1);

    // R10: plain clear drops the flag
    pulse_clr();
    chk("R10 clear", {31'b0, flag}, 32'h0);

    // R10: clear coinciding with a clamp leaves the flag set
    run_op(4'd4, 5'd0, 32'h0, 32'h1, 1'b1);
    chk("R10 set over clear", {31'b0, flag}, 32'h1);

    // R10: clear alongside a clean op clears
    run_op(4'd0, 5'd0, 32'h1, 32'h1, 1'b1);
    chk("R10 clear with clean op", {31'b0, flag}, 32'h0);

    // R11: clamping inputs with valid low touch nothing
    @(negedge clk);
    op = 4'd3; a = 32'hFFFFFFFF; b = 32'hFFFFFFFF; valid = 1'b0;
    repeat (2) @(negedge clk);
    chk("R11 hold result", result, 32'h2);
    chk("R11 hold flag", {31'b0, flag}, 32'h0);

    // R5: position zero clamps to 0 / -1
    run_op(4'd5, 5'd0, 32'h00000009, 32'h0, 1'b0);
    chk("R5 pos0 high", result, 32'h0);
    run_op(4'd5, 5'd0, 32'hFFFFFFF0, 32'h0, 1'b0);
    chk("R5 pos0 low", result, 32'hFFFFFFFF);

    finish_run();
  end
endmodule